// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address by reading a two-level page table that sits in memory. The incoming address is already linear, because the segment base is zero. Its top ten bits pick a word in a 4 KB directory. The directory's base is latched from a root-pointer input when the request is accepted. That directory word gives the base of a 4 KB second-level table, and the next ten bits of the address pick a word in that table. The second-level word gives the page frame, and the low twelve bits of the address are kept unchanged as the byte offset.

A request enters through a valid/ready handshake. The walker then issues at most two word reads on a simple read port that waits for an acknowledge. Each directory and table word carries three flag bits: present, write-enable and user-access. A directory word with its present bit clear stands for a whole unmapped 4 MB region, so no second-level table is needed for it. Each walk ends with a one-cycle done pulse. The pulse carries either the physical address or a fault code, together with the linear address that was walked.

Top module: `ptw_walker`

## Requirements
- R1: After reset `req_ready` is 1 and `mem_rd_valid` and `done` are 0. `req_ready` is 1 only while no walk is in progress, and a request is taken when `req_valid` and `req_ready` are both 1.
- R2: The first read of a walk goes to address {root[31:12], va[31:22], 2'b00}. Here root is the `root_base` value sampled when the request was accepted, so a later change to `root_base` has no effect on that walk.
- R3: The second read goes to address {dir_word[31:12], va[21:12], 2'b00}, where dir_word is the data returned by the first read.
- R4: When no fault occurs, `done_paddr` = {tbl_word[31:12], va[11:0]} and `done_fault` = 0.
- R5: If bit 0 (present) of the directory word is 0, the walk ends with `done_fault` = 1 (not present), and no second read is issued.
- R6: If bit 0 of the table word is 0, the walk ends with `done_fault` = 1, even when the access rights would also fail.
- R7: A write (`req_write`=1) to a present page faults with `done_fault` = 2 (protection) unless bit 1 (write-enable) is 1 in both words.
- R8: A user access (`req_user`=1) to a present page faults with `done_fault` = 2 unless bit 2 (user) is 1 in both words. A supervisor read ignores bits 1 and 2.
- R9: `mem_rd_valid` stays 1 with a stable `mem_rd_addr` until a cycle in which `mem_rd_ack` is 1. `mem_rd_data` is taken in that same cycle.
- R10: Each accepted request yields exactly one `done` pulse, one cycle wide, in the cycle after the last acknowledged read. `done_vaddr` equals the request's address, and `done_fault` is never 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| root_base | input | 32 | Physical base of the directory (control register) |
| mem_rd_valid | output | 1 | Read request to memory |
| mem_rd_addr | output | 32 | Word address of the read |
| mem_rd_ack | input | 1 | Memory accepts the read and returns data |
| mem_rd_data | input | 32 | Read data, valid with the acknowledge |
| done | output | 1 | One-cycle completion pulse |
| done_paddr | output | 32 | Physical address (0 on fault) |
| done_fault | output | 2 | 0 none, 1 not present, 2 protection |
| done_vaddr | output | 32 | Linear address of the finished walk |

## Verification
The bench goes after unmapped directory regions. A walker that ignored the present bit would issue a second read into a table that does not exist, and would return a bogus frame instead of fault code 1. It mixes cases where only one of the two words lacks the write or user bit, which catches a design that checks only the last level. It also covers a table word that is both absent and forbidden, which shows whether a not-present fault is wrongly reported as a protection fault. The bench acknowledges reads after random delays and rewrites `root_base` in the middle of a walk. A design that dropped the address before the acknowledge, or that read the live root value, would show a wrong read address.

// File: rtl/ptw_pkg.sv
// Shared constants and types for the page table walker.
// Assumes 4 KB pages, 4-byte table words and 1024-entry tables.
package ptw_pkg;
    localparam int unsigned VA_W     = 32;
    localparam int unsigned OFF_W    = 12;
    localparam int unsigned IDX_W    = 10;
    localparam int unsigned ENT_LOG2 = 2;
    localparam int unsigned FLAG_PRESENT = 0;
    localparam int unsigned FLAG_WRITE   = 1;
    localparam int unsigned FLAG_USER    = 2;

    typedef enum logic [1:0] {
        WALK_IDLE = 2'd0,
        WALK_DIR  = 2'd1,
        WALK_TBL  = 2'd2
    } walk_state_t;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_PROT   = 2'd2
    } fault_t;
endpackage

// File: rtl/ptw_addr_split.sv
// Splits a linear address into directory index, table index and byte offset.
// Assumes ADDR_W = 2*IDX_W + OFF_W.
module ptw_addr_split #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 12,
    parameter int unsigned IDX_W  = 10
) (
    input  logic [ADDR_W-1:0] lin_addr,
    output logic [IDX_W-1:0]  dir_idx,
    output logic [IDX_W-1:0]  tbl_idx,
    output logic [OFF_W-1:0]  byte_off
);
    localparam int unsigned TBL_LO = OFF_W;
    localparam int unsigned DIR_LO = OFF_W + IDX_W;

    // Slice the three fields out of the address.
    always_comb begin
        dir_idx  = lin_addr[DIR_LO +: IDX_W];
        tbl_idx  = lin_addr[TBL_LO +: IDX_W];
        byte_off = lin_addr[OFF_W-1:0];
    end
endmodule

// File: rtl/ptw_entry_addr.sv
// Forms the byte address of a table word: base with its page offset cleared,
// plus index times word size. Uses concatenation when the index exactly
// fills the page offset, otherwise an adder.
module ptw_entry_addr #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned OFF_W    = 12,
    parameter int unsigned IDX_W    = 10,
    parameter int unsigned ENT_LOG2 = 2
) (
    input  logic [ADDR_W-1:0] table_base,
    input  logic [IDX_W-1:0]  index,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int unsigned BASE_W = ADDR_W - OFF_W;

    generate
        if (IDX_W + ENT_LOG2 == OFF_W) begin : g_concat
            // Index bits fill the offset field exactly.
            always_comb entry_addr = {table_base[ADDR_W-1:OFF_W], index, {ENT_LOG2{1'b0}}};
        end else begin : g_add
            logic [ADDR_W-1:0] scaled;
            // General case: aligned base plus scaled index.
            always_comb begin
                scaled     = ADDR_W'(index) << ENT_LOG2;
                entry_addr = {table_base[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} + scaled;
            end
            logic [BASE_W-1:0] unused_w;
            always_comb unused_w = '0;
        end
    endgenerate
endmodule

// File: rtl/ptw_perm_check.sv
// Classifies the outcome of a walk from both table words and the access kind.
// Assumes the directory word is already known to be present.
module ptw_perm_check
    import ptw_pkg::*;
(
    input  logic [2:0] dir_flags,
    input  logic [2:0] tbl_flags,
    input  logic       is_write,
    input  logic       is_user,
    output fault_t     verdict
);
    logic write_ok;
    logic user_ok;

    // Rights are the AND of both levels; absence outranks protection.
    always_comb begin
        write_ok = dir_flags[FLAG_WRITE] & tbl_flags[FLAG_WRITE];
        user_ok  = dir_flags[FLAG_USER]  & tbl_flags[FLAG_USER];
        if (!tbl_flags[FLAG_PRESENT])
            verdict = FLT_ABSENT;
        else if ((is_write && !write_ok) || (is_user && !user_ok))
            verdict = FLT_PROT;
        else
            verdict = FLT_NONE;
    end

    logic unused_dir_present;
    always_comb unused_dir_present = dir_flags[FLAG_PRESENT];
endmodule

// File: rtl/ptw_walker.sv
// Two-level page table walker. Accepts one request when idle, latches the
// root pointer, reads the directory word and then (if present) the table
// word, holding each read until acknowledged. Ends with a one-cycle done
// pulse carrying the physical address or a fault code.
// Assumes memory returns data in the cycle of the acknowledge.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int unsigned ADDR_W   = VA_W,
    parameter int unsigned OFF_W    = ptw_pkg::OFF_W,
    parameter int unsigned IDX_W    = ptw_pkg::IDX_W,
    parameter int unsigned ENT_LOG2 = ptw_pkg::ENT_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [ADDR_W-1:0] root_base,
    output logic              mem_rd_valid,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_ack,
    input  logic [ADDR_W-1:0] mem_rd_data,
    output logic              done,
    output logic [ADDR_W-1:0] done_paddr,
    output logic [1:0]        done_fault,
    output logic [ADDR_W-1:0] done_vaddr
);
    localparam int unsigned FRAME_W = ADDR_W - OFF_W;

    walk_state_t         state_q;
    logic [ADDR_W-1:0]   va_q;
    logic [ADDR_W-1:0]   root_q;
    logic [ADDR_W-1:0]   dir_word_q;
    logic                wr_q;
    logic                usr_q;
    logic                done_q;
    fault_t              fault_q;
    logic [ADDR_W-1:0]   paddr_q;

    logic [IDX_W-1:0]    dir_idx;
    logic [IDX_W-1:0]    tbl_idx;
    logic [OFF_W-1:0]    byte_off;
    logic [ADDR_W-1:0]   dir_entry_addr;
    logic [ADDR_W-1:0]   tbl_entry_addr;
    fault_t              tbl_verdict;
    logic                rd_fire;

    ptw_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split (
        .lin_addr (va_q),
        .dir_idx  (dir_idx),
        .tbl_idx  (tbl_idx),
        .byte_off (byte_off)
    );

    ptw_entry_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_LOG2(ENT_LOG2)) u_dir_addr (
        .table_base (root_q),
        .index      (dir_idx),
        .entry_addr (dir_entry_addr)
    );

    ptw_entry_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_LOG2(ENT_LOG2)) u_tbl_addr (
        .table_base (dir_word_q),
        .index      (tbl_idx),
        .entry_addr (tbl_entry_addr)
    );

    ptw_perm_check u_perm (
        .dir_flags (dir_word_q[2:0]),
        .tbl_flags (mem_rd_data[2:0]),
        .is_write  (wr_q),
        .is_user   (usr_q),
        .verdict   (tbl_verdict)
    );

    // Drive the handshake and read port from the walk state.
    always_comb begin
        req_ready    = (state_q == WALK_IDLE);
        mem_rd_valid = (state_q != WALK_IDLE);
        mem_rd_addr  = (state_q == WALK_TBL) ? tbl_entry_addr : dir_entry_addr;
        rd_fire      = mem_rd_valid && mem_rd_ack;
    end

    // Walk sequencer: accept, read directory, read table, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= WALK_IDLE;
            va_q       <= '0;
            root_q     <= '0;
            dir_word_q <= '0;
            wr_q       <= 1'b0;
            usr_q      <= 1'b0;
            done_q     <= 1'b0;
            fault_q    <= FLT_NONE;
            paddr_q    <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                WALK_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_vaddr;
                        root_q  <= root_base;
                        wr_q    <= req_write;
                        usr_q   <= req_user;
                        state_q <= WALK_DIR;
                    end
                end
                WALK_DIR: begin
                    if (rd_fire) begin
                        dir_word_q <= mem_rd_data;
                        if (!mem_rd_data[FLAG_PRESENT]) begin
                            done_q  <= 1'b1;
                            fault_q <= FLT_ABSENT;
                            paddr_q <= '0;
                            state_q <= WALK_IDLE;
                        end else begin
                            state_q <= WALK_TBL;
                        end
                    end
                end
                WALK_TBL: begin
                    if (rd_fire) begin
                        done_q  <= 1'b1;
                        fault_q <= tbl_verdict;
                        paddr_q <= (tbl_verdict == FLT_NONE)
                                   ? {mem_rd_data[ADDR_W-1:OFF_W], byte_off} : '0;
                        state_q <= WALK_IDLE;
                    end
                end
                default: state_q <= WALK_IDLE;
            endcase
        end
    end

    // Present the registered response.
    always_comb begin
        done       = done_q;
        done_fault = fault_q;
        done_paddr = paddr_q;
        done_vaddr = va_q;
    end

    logic [FRAME_W-1:0] unused_frame;
    always_comb unused_frame = '0;
endmodule

// File: rtl/ptw_walker_chk.sv
// Property checker for ptw_walker, bound to every instance.
// Tracks which read of a walk is pending to check the directory address.
module ptw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_vaddr,
    input logic [31:0] root_base,
    input logic        mem_rd_valid,
    input logic [31:0] mem_rd_addr,
    input logic        mem_rd_ack,
    input logic        done,
    input logic [31:0] done_paddr,
    input logic [1:0]  done_fault,
    input logic [31:0] done_vaddr
);
    logic        second_rd;
    logic [31:0] root_l;
    logic [31:0] va_l;

    // Mirror acceptance and read progress of the current walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            second_rd <= 1'b0;
            root_l    <= '0;
            va_l      <= '0;
        end else if (req_valid && req_ready) begin
            second_rd <= 1'b0;
            root_l    <= root_base;
            va_l      <= req_vaddr;
        end else if (mem_rd_valid && mem_rd_ack) begin
            second_rd <= 1'b1;
        end
    end

    assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !req_ready);

    assert_dir_address_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !second_rd) |-> (mem_rd_addr == {root_l[31:12], va_l[31:22], 2'b00}));

    assert_offset_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_fault == 2'd0) |-> (done_paddr[11:0] == done_vaddr[11:0]));

    assert_hold_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ack) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_code_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_fault != 2'd3));
endmodule

bind ptw_walker ptw_walker_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_vaddr    (req_vaddr),
    .root_base    (root_base),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_ack   (mem_rd_ack),
    .done         (done),
    .done_paddr   (done_paddr),
    .done_fault   (done_fault),
    .done_vaddr   (done_vaddr)
);

// File: tb/ptw_walker_test.sv
// Bench for ptw_walker: sparse memory model with random acknowledge delay,
// directed corners plus seeded random walks checked by a reference function.
module ptw_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [31:0] root_base = '0;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ack = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        done;
    logic [31:0] done_paddr;
    logic [1:0]  done_fault;
    logic [31:0] done_vaddr;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int n_reads = 0;
    logic [31:0] rd_log [4];
    int ack_wait = 0;
    logic [31:0] mem [logic [31:0]];

    always #4 clk = ~clk;

    ptw_walker uut (.*);

    // Watchdog and cycle count.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    function automatic logic [31:0] rd_mem(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Memory responder: acks after 0..2 cycles, data valid with ack.
    always @(negedge clk) begin
        mem_rd_ack = 1'b0;
        if (mem_rd_valid) begin
            if (ack_wait == 0) begin
                mem_rd_ack  = 1'b1;
                mem_rd_data = rd_mem(mem_rd_addr);
                if (n_reads < 4) rd_log[n_reads] = mem_rd_addr;
                n_reads++;
                ack_wait = $urandom % 3;
            end else ack_wait--;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model and one walk through the block.
    task automatic walk(input logic [31:0] va, input logic w, input logic u, input logic [31:0] root,
                        input logic poke_root);
        logic [31:0] da, de, ta, te, exp_pa;
        int exp_reads, n;
        logic [1:0] exp_f;
        da = {root[31:12], va[31:22], 2'b00};
        de = rd_mem(da);
        ta = {de[31:12], va[21:12], 2'b00};
        te = rd_mem(ta);
        exp_pa = 32'h0;
        if (!de[0]) begin exp_f = 2'd1; exp_reads = 1; end
        else begin
            exp_reads = 2;
            if (!te[0]) exp_f = 2'd1;
            else if ((w && !(de[1] && te[1])) || (u && !(de[2] && te[2]))) exp_f = 2'd2;
            else begin exp_f = 2'd0; exp_pa = {te[31:12], va[11:0]}; end
        end
        n_reads = 0;
        @(negedge clk);
        check("R1 ready when idle", {31'b0, req_ready}, 32'd1);
        req_valid = 1'b1; req_vaddr = va; req_write = w; req_user = u; root_base = root;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke_root) root_base = ~root;
        check("R1 busy not ready", {31'b0, req_ready}, 32'd0);
        n = 0;
        while (!done && n < 50) begin @(negedge clk); n++; end
        check("R10 done seen", {31'b0, done}, 32'd1);
        check("R2 dir address", rd_log[0], da);
        if (exp_reads == 2) check("R3 table address", rd_log[1], ta);
        check(exp_reads == 1 ? "R5 read count" : "R10 read count", n_reads, exp_reads);
        check(exp_f == 2'd0 ? "R4 fault code" : (exp_f == 2'd1 ? "R5/R6 absent code" : "R7/R8 protection code"),
              {30'b0, done_fault}, {30'b0, exp_f});
        check("R4 physical address", done_paddr, exp_pa);
        check("R10 vaddr echo", done_vaddr, va);
        @(negedge clk);
        check("R10 one-cycle pulse", {31'b0, done}, 32'd0);
        root_base = root;
    endtask

    localparam logic [31:0] ROOT  = 32'h0010_0000;
    localparam logic [31:0] ROOT2 = 32'h0030_0000;

    initial begin
        void'($urandom(32'd1234));
        // Directory: entries 0..7 random flags, table at 0x0020_0000+i*4K.
        for (int i = 0; i < 8; i++) begin
            mem[ROOT + i*4] = (32'h0020_0000 + i*4096) | ($urandom % 8) | 32'h1;
            for (int j = 0; j < 16; j++)
                mem[32'h0020_0000 + i*4096 + j*4] = {$urandom % 32'h100000, 9'b0, 3'($urandom)};
        end
        mem[ROOT + 2*4] = 32'h0020_2000; // R5 unmapped region (present bit clear)
        mem[ROOT + 8*4] = 32'h0050_0007; // full rights directory
        mem[32'h0050_0000] = 32'hABCD_E007; // full-rights page
        mem[32'h0050_0004] = 32'h1234_5003; // no user bit
        mem[32'h0050_0008] = 32'h5555_5005; // no write bit
        mem[32'h0050_000C] = 32'h7777_7006; // absent but rights look fine
        mem[32'h0050_0010] = 32'h0000_0000; // absent and no rights (R6 outranks)
        mem[ROOT + 9*4] = 32'h0060_0001; // supervisor-only read-only dir
        mem[32'h0060_0000] = 32'h9999_9007;
        mem[ROOT2 + 8*4] = 32'h0060_0005; // second root, user read-only dir
        mem[32'h0060_0004] = 32'h4444_4007;

        repeat (3) @(negedge clk);
        check("R1 reset ready", {31'b0, req_ready}, 32'd1);
        check("R1 reset no read", {31'b0, mem_rd_valid}, 32'd0);
        check("R1 reset no done", {31'b0, done}, 32'd0);
        rst_n = 1'b1;

        walk(32'h0200_0123, 1'b1, 1'b1, ROOT, 1'b0);                 // R4 full rights
        walk(32'h0200_1FFF, 1'b0, 1'b1, ROOT, 1'b0);                 // R8 user denied
        walk(32'h0200_1FFF, 1'b1, 1'b0, ROOT, 1'b0);                 // R4 supervisor write ok
        walk(32'h0200_2010, 1'b1, 1'b0, ROOT, 1'b0);                 // R7 write denied
        walk(32'h0200_2010, 1'b0, 1'b1, ROOT, 1'b0);                 // R8 user read ok
        walk(32'h0200_3000, 1'b0, 1'b0, ROOT, 1'b0);                 // R6 absent page
        walk(32'h0200_4444, 1'b1, 1'b1, ROOT, 1'b0);                 // R6 absent beats protection
        walk(32'h0080_0ABC, 1'b1, 1'b1, ROOT, 1'b0);                 // R5 unmapped region
        walk(32'h0240_0004, 1'b1, 1'b0, ROOT, 1'b0);                 // R7 dir lacks write
        walk(32'h0240_0004, 1'b0, 1'b1, ROOT, 1'b0);                 // R8 dir lacks user
        walk(32'h0240_0004, 1'b0, 1'b0, ROOT, 1'b0);                 // R8 supervisor read ignores flags
        walk(32'h0200_1567, 1'b0, 1'b1, ROOT2, 1'b1);                // R2 root latched, R4 user read
        walk(32'h0200_1567, 1'b1, 1'b1, ROOT2, 1'b1);                // R7 via second root
        walk(32'h3FC0_0000, 1'b0, 1'b0, ROOT, 1'b0);                 // R5 never-written entry

        for (int k = 0; k < 300; k++) begin
            logic [31:0] va;
            va = {($urandom % 12) == 11 ? 10'd2 : 10'($urandom % 10), 10'($urandom % 20), 12'($urandom)};
            walk(va, 1'($urandom), 1'($urandom), ROOT, 1'($urandom));
        end

        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule